// File: doc/BRIEF.md
# Pipelined Tag-Steered Flit Splitter Tree

This block sits at the receiving end of a shared link that carries flits from several virtual channels. Each incoming flit carries a payload and a route tag that names the channel it belongs to. A binary tree of two-way branch nodes delivers the flit to the matching output. Each node reads one tag bit, picks its low or high child, and passes on a flit that is one bit narrower. The leaves therefore see the bare payload.

Every branch node holds a one-flit register, so each tree level is one pipeline stage. The handshakes are valid/ready on both sides. A stalled output holds up only the nodes on its own path, up to the first node where that path is shared with traffic that is still waiting. The channel count must be a power of two and at least two.

Top module: `horn_tree`

## Requirements
- R1: The input flit is `{tag, payload}`. The tag occupies bits [PAYLOAD_W+TAG_W-1:PAYLOAD_W]. The root node decodes the most significant tag bit, with 0 meaning the lower half of the outputs. A flit whose tag is t is presented only on output t.
- R2: The data on output t equals input bits [PAYLOAD_W-1:0] of the flit. All tag bits are removed.
- R3: Within any one channel, flits leave in the order they were accepted. No flit is lost, duplicated or produced without a matching input.
- R4: Suppose the tree is empty and every output is ready, and a flit is accepted at clock edge k. Its output valid rises just after edge k+TAG_W-1 and stays low before that edge.
- R5: While an output is valid and its ready is low, the valid stays high and the data stays unchanged.
- R6: A flit blocked at one output does not stop flits bound for the other half of the tree at the root. Those flits keep flowing as long as the root register is not holding the blocked flit.
- R7: At most NUM_CH-1 flits are in flight. When the tree is empty, in_ready_o is high. When the root holds a flit whose path is blocked, in_ready_o is low.
- R8: When every output is ready, in_ready_o is high, so one flit is accepted per cycle.
- R9: While reset is asserted, all output valids are low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Incoming flit valid |
| in_ready_o | output | 1 | Root can take a flit |
| in_flit_i | input | PAYLOAD_W+TAG_W | Tag in upper bits, payload in lower bits |
| out_valid_o | output | NUM_CH | Per-channel flit valid |
| out_ready_i | input | NUM_CH | Per-channel sink ready |
| out_data_o | output | NUM_CH*PAYLOAD_W | Channel c payload at bits [c*PAYLOAD_W +: PAYLOAD_W] |

## Verification
A wrong bit decoded at any level sends a flit to the wrong leaf. The error shows on the very first flit that should take the other branch, either as an unexpected arrival or as a payload mismatch on that channel. A node register that drops or overwrites its contents under stall shows up as a changed or withdrawn output one cycle after the stall begins. It also leaves entries behind in the per-channel scoreboard when the bench drains the tree. Ready logic that couples unrelated subtrees shows up as a lost cycle during full-rate traffic, or as a blocked delivery in the isolation scenario, within a few cycles.

// File: rtl/horn_pkg.sv
package horn_pkg;

  // level of a node in heap numbering (root = 1 at level 0)
  function automatic int unsigned heap_level(int unsigned n);
    int unsigned l = 0;
    for (int i = 1; i < 32; i++) if ((n >> i) != 0) l = i;
    return l;
  endfunction

  // bit offset of the first edge at a tree level in the flattened edge bus
  function automatic int unsigned lvl_offset(int unsigned fw, int unsigned lvl);
    int unsigned s = 0;
    for (int unsigned j = 0; j < lvl; j++) s += (32'd1 << j) * (fw - j);
    return s;
  endfunction

endpackage

// File: rtl/horn_pipe_reg.sv
module horn_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready_o  = ~full_q | out_ready_i;
  assign out_valid_o = full_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_ready_o) full_q <= in_valid_i;
      if (in_valid_i && in_ready_o) data_q <= in_data_i;
    end
  end
endmodule

// File: rtl/horn_branch_node.sv
module horn_branch_node #(
  parameter int unsigned DW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  output logic          lo_valid_o,
  input  logic          lo_ready_i,
  output logic          hi_valid_o,
  input  logic          hi_ready_i,
  output logic [DW-2:0] child_data_o
);
  logic          held_valid;
  logic          held_ready;
  logic [DW-1:0] held_data;
  logic          go_hi;

  horn_pipe_reg #(.W(DW)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .out_valid_o (held_valid),
    .out_ready_i (held_ready),
    .out_data_o  (held_data)
  );

  // top bit of the held flit is this level's tag bit
  assign go_hi        = held_data[DW-1];
  assign lo_valid_o   = held_valid & ~go_hi;
  assign hi_valid_o   = held_valid &  go_hi;
  assign held_ready   = go_hi ? hi_ready_i : lo_ready_i;
  assign child_data_o = held_data[DW-2:0];
endmodule

// File: rtl/horn_tree.sv
module horn_tree
  import horn_pkg::*;
#(
  parameter  int unsigned PAYLOAD_W = 8,
  parameter  int unsigned NUM_CH    = 4,
  localparam int unsigned TAG_W     = $clog2(NUM_CH),
  localparam int unsigned FLIT_W    = PAYLOAD_W + TAG_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic [FLIT_W-1:0]           in_flit_i,
  output logic [NUM_CH-1:0]           out_valid_o,
  input  logic [NUM_CH-1:0]           out_ready_i,
  output logic [NUM_CH*PAYLOAD_W-1:0] out_data_o
);
  localparam int unsigned EDGE_W  = lvl_offset(FLIT_W, TAG_W + 1);
  localparam int unsigned LEAF_AT = lvl_offset(FLIT_W, TAG_W);

  // edges in heap numbering: edge n feeds node n; edges NUM_CH.. are leaves
  logic [2*NUM_CH-1:1] e_valid;
  logic [2*NUM_CH-1:1] e_ready;
  logic [EDGE_W-1:0]   e_data;

  assign e_valid[1]        = in_valid_i;
  assign in_ready_o        = e_ready[1];
  assign e_data[0+:FLIT_W] = in_flit_i;

  for (genvar n = 1; n < NUM_CH; n++) begin : g_node
    localparam int unsigned LVL    = heap_level(n);
    localparam int unsigned DW     = FLIT_W - LVL;
    localparam int unsigned POS    = n - (1 << LVL);
    localparam int unsigned IN_AT  = lvl_offset(FLIT_W, LVL) + POS * DW;
    localparam int unsigned OUT_AT = lvl_offset(FLIT_W, LVL + 1) + 2 * POS * (DW - 1);

    logic [DW-2:0] stripped;

    horn_branch_node #(.DW(DW)) u_node (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .in_valid_i   (e_valid[n]),
      .in_ready_o   (e_ready[n]),
      .in_data_i    (e_data[IN_AT+:DW]),
      .lo_valid_o   (e_valid[2*n]),
      .lo_ready_i   (e_ready[2*n]),
      .hi_valid_o   (e_valid[2*n+1]),
      .hi_ready_i   (e_ready[2*n+1]),
      .child_data_o (stripped)
    );

    assign e_data[OUT_AT+:(DW-1)]        = stripped;
    assign e_data[OUT_AT+DW-1+:(DW-1)]   = stripped;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_leaf
    assign out_valid_o[c]                      = e_valid[NUM_CH+c];
    assign e_ready[NUM_CH+c]                   = out_ready_i[c];
    assign out_data_o[c*PAYLOAD_W+:PAYLOAD_W]  = e_data[LEAF_AT+c*PAYLOAD_W+:PAYLOAD_W];
  end
endmodule

// File: rtl/horn_tree_chk.sv
module horn_tree_chk #(
  parameter int unsigned PAYLOAD_W = 8,
  parameter int unsigned NUM_CH    = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        in_valid_i,
  input logic                        in_ready_o,
  input logic [NUM_CH-1:0]           out_valid_o,
  input logic [NUM_CH-1:0]           out_ready_i,
  input logic [NUM_CH*PAYLOAD_W-1:0] out_data_o
);
  localparam int unsigned CNT_W = $clog2(NUM_CH) + 2;

  logic [CNT_W-1:0] inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else inflight_q <= inflight_q + CNT_W'(in_valid_i && in_ready_o)
                                  - CNT_W'($countones(out_valid_o & out_ready_i));
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R9: assert (out_valid_o == '0 && in_ready_o);
    end
  end

  assert_capacity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CNT_W'(NUM_CH - 1));

  assert_empty_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q == '0 |-> in_ready_o);

  assert_no_phantom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o != '0 |-> inflight_q != '0);

  assert_full_rate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &out_ready_i |-> in_ready_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[c] && !out_ready_i[c] |=>
        out_valid_o[c] && $stable(out_data_o[c*PAYLOAD_W+:PAYLOAD_W]));
  end
endmodule

bind horn_tree horn_tree_chk #(.PAYLOAD_W(PAYLOAD_W), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/horn_tree_tb_top.sv
module horn_tree_tb_top;
  localparam int PW = 8;
  localparam int NC = 4;
  localparam int TW = 2;
  localparam int FW = PW + TW;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [FW-1:0]    in_flit = '0;
  logic [NC-1:0]    out_valid;
  logic [NC-1:0]    out_ready = '0;
  logic [NC*PW-1:0] out_data;

  int checks = 0;
  int fails = 0;
  int stall_cnt = 0;
  int ready_mode = 0;
  logic [NC-1:0] manual_ready = '1;
  int cyc = 0;

  // per-channel scoreboard rings
  logic [PW-1:0] ring [NC][16];
  int wr_p [NC];
  int rd_p [NC];
  int cnt [NC];
  int deliv [NC];
  logic held_prev [NC];
  logic [PW-1:0] held_data [NC];

  always #(HALF) clk = ~clk;

  horn_tree #(.PAYLOAD_W(PW), .NUM_CH(NC)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_flit_i   (in_flit),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data)
  );

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (ready_mode)
      0: out_ready <= '1;
      1: for (int c = 0; c < NC; c++) out_ready[c] <= ((cyc * (c + 3) + c) % 5) >= 2;
      default: out_ready <= manual_ready;
    endcase
  end

  // monitor, sampled one time unit before the rising edge
  initial begin
    for (int c = 0; c < NC; c++) begin
      wr_p[c] = 0; rd_p[c] = 0; cnt[c] = 0; deliv[c] = 0; held_prev[c] = 1'b0; held_data[c] = '0;
    end
    forever begin
      @(negedge clk);
      #(HALF - 1);
      if (rst_n) begin
        if (in_valid && in_ready) begin
          int t;
          t = int'(in_flit[FW-1:PW]);
          ring[t][wr_p[t]] = in_flit[PW-1:0];
          wr_p[t] = (wr_p[t] + 1) % 16;
          cnt[t]++;
        end
        for (int c = 0; c < NC; c++) begin
          logic [PW-1:0] d;
          d = out_data[c*PW+:PW];
          if (out_valid[c]) begin
            if (held_prev[c]) chk(d == held_data[c], "R5", "held data", int'(d), int'(held_data[c]));
            if (out_ready[c]) begin
              if (cnt[c] == 0) begin
                chk(1'b0, "R1", "flit on channel with none pending", c, -1);
              end else begin
                chk(d == ring[c][rd_p[c]], "R2/R3", "payload in order", int'(d), int'(ring[c][rd_p[c]]));
                rd_p[c] = (rd_p[c] + 1) % 16;
                cnt[c]--;
              end
              deliv[c]++;
            end
          end else if (held_prev[c]) begin
            chk(1'b0, "R5", "valid withdrawn under stall", 0, 1);
          end
          held_prev[c] = out_valid[c] && !out_ready[c];
          held_data[c] = d;
        end
      end
    end
  end

  // caller is at a falling edge; returns at the falling edge after acceptance
  task automatic send(input int ch, input int pl);
    logic ok;
    in_valid = 1'b1;
    in_flit  = {TW'(ch), PW'(pl)};
    do begin
      #(HALF - 1);
      ok = in_ready;
      @(negedge clk);
      if (!ok) stall_cnt++;
    end while (!ok);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    int d0, d2;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_valid == '0, "R9", "valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    idle(2);

    // R4 latency per channel
    ready_mode = 0;
    for (int c = 0; c < NC; c++) begin
      in_valid = 1'b1;
      in_flit  = {TW'(c), PW'(8'hA0 + c)};
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == '0, "R4", "valid before edge k+1", int'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == NC'(1 << c), "R4", "valid after edge k+1", int'(out_valid), 1 << c);
      idle(3);
    end

    // R1 R2 R8 full-rate sweep over every tag and payload
    stall_cnt = 0;
    for (int p = 0; p < 256; p++)
      for (int c = 0; c < NC; c++) send(c, (p ^ (c * 37)) & 8'hFF);
    idle(6);
    chk(stall_cnt == 0, "R8", "stalled cycles at full rate", stall_cnt, 0);

    // R3 R5 with output back-pressure and input gaps
    ready_mode = 1;
    for (int i = 0; i < 1024; i++) begin
      send((i * 3 + i / 7) % NC, (i * 13) & 8'hFF);
      if (i % 5 == 0) idle(1);
    end
    idle(2);
    ready_mode = 0;
    idle(10);

    // R6 R7 stall isolation and root blocking
    manual_ready = 4'b1110;
    ready_mode = 2;
    idle(2);
    send(0, 8'h11);
    idle(2);
    d0 = deliv[0];
    d2 = deliv[2];
    send(2, 8'h22);
    idle(3);
    chk(deliv[2] == d2 + 1, "R6", "other subtree delivered", deliv[2], d2 + 1);
    chk(out_valid[0] == 1'b1 && deliv[0] == d0, "R6", "blocked flit still held", int'(out_valid[0]), 1);
    send(1, 8'h33);
    in_valid = 1'b1;
    in_flit  = {TW'(3), PW'(8'h44)};
    #(HALF - 1);
    chk(in_ready == 1'b0, "R7", "in_ready with blocked root", int'(in_ready), 0);
    @(negedge clk);
    #(HALF - 1);
    chk(in_ready == 1'b0 && out_valid[1] == 1'b0, "R7", "root stays blocked", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    manual_ready = '1;
    idle(8);
    chk(deliv[1] == 0 || out_valid == '0, "R7", "tree drained after release", int'(out_valid), 0);

    // R3 nothing left behind
    for (int c = 0; c < NC; c++) chk(cnt[c] == 0, "R3", "flits left in channel", cnt[c], 0);

    summary();
    $finish;
  end
endmodule